// File: doc/BRIEF.md
# Performance Event Counter Bank

This block holds six free-running event counters for a multi-cycle processor whose memory channels use valid/ready handshakes. The processor supplies a one-hot vector that shows its current control state. It also supplies the memory request-ready signal, the read-data-valid signal and a flag that is high when a branch is taken. Each cycle the bank turns these into up to six increment events: elapsed cycles, executed instructions, accepted memory accesses, memory stall cycles, taken branches and branches that are not taken.

Software reads the counters through a simple read port. A read is accepted in any cycle in which the read enable is high. The selected counter comes back on the next cycle. Each counter sits at its own fixed byte address inside a sparse window. The bank also reports a state vector that is not one-hot, so that a broken control sequencer is visible. While it does this, each counter still follows its own state bit.

Top module: `perf_counter_bank`

## Requirements
- R1: The cycle counter (slot 0) increases by one on every clock edge at which reset is low.
- R2: The instruction counter (slot 1) increases by one on every edge at which state bit 2 (execute) is high, and it holds otherwise.
- R3: The access counter (slot 2) increases by one on every edge at which bit 3 (load request) or bit 4 (store request) is high and mem_req_ready is high.
- R4: The stall counter (slot 3) increases by one on every edge at which bit 3 or bit 4 is high with mem_req_ready low, or bit 5 (read-data wait) is high with rdata_valid low. It holds otherwise.
- R5: In an execute cycle, slot 4 increases when branch_taken is high and slot 5 increases when it is low. Neither counter changes outside the execute state.
- R6: Slot k is read at byte address BASE + (k div 2) * 0x1000 + (k mod 2) * 8, which with the default BASE of 0x60010000 gives 0x60010000, 0x60010008, 0x60011000, 0x60011008, 0x60012000 and 0x60012008. All 32 address bits must match.
- R7: A read at any address that is not one of the six slot addresses returns 0.
- R8: A read accepted in cycle n shows its data from cycle n+1, equal to the counter value before the edge that ends cycle n. While rd_en is low, rd_data keeps its last value.
- R9: A synchronous active-high reset clears every counter, rd_data and state_fault.
- R10: The counters wrap from all ones to zero without any indication. Counters narrower than 32 bits are zero-extended on rd_data.
- R11: state_fault is high in the cycle after any cycle in which the state vector does not have exactly one bit set, including when it is all zeros, and low after a one-hot cycle. The counters still act on the individual state bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fsm_state | input | 6 | One-hot processor state: 0 fetch request, 1 fetch wait, 2 execute, 3 load request, 4 store request, 5 read-data wait |
| mem_req_ready | input | 1 | Memory request channel ready |
| rdata_valid | input | 1 | Read-data response channel valid |
| branch_taken | input | 1 | Branch taken in the execute cycle |
| rd_en | input | 1 | Read request, accepted in any cycle |
| rd_addr | input | 32 | Byte address of the read |
| rd_data | output | 32 | Read result, one cycle after the accept |
| state_fault | output | 1 | State vector was not one-hot in the previous cycle |

## Verification
Both registered outputs are due one edge after the stimulus that sets them. rd_data reflects the counter values before that edge. state_fault reflects the state vector that was present at that edge. The bench works out each expectation from its own event model before it updates that model. It then drives the stimulus, waits for the rising edge and samples one time unit later, before it changes any input. A second instance with 8-bit counters receives the same stimulus so that the wrap case can be reached within the run.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;

    localparam int N_ST   = 6;
    localparam int N_CNT  = 6;
    localparam int DATA_W = 32;

    // state vector bit positions
    localparam int S_FREQ  = 0;
    localparam int S_FWAIT = 1;
    localparam int S_EXEC  = 2;
    localparam int S_LOAD  = 3;
    localparam int S_STORE = 4;
    localparam int S_RWAIT = 5;

    // counter slots
    localparam int E_CYC  = 0;
    localparam int E_EXEC = 1;
    localparam int E_ACC  = 2;
    localparam int E_DLY  = 3;
    localparam int E_TKN  = 4;
    localparam int E_NTK  = 5;

    localparam logic [31:0] GROUP_STRIDE = 32'h0000_1000;
    localparam logic [31:0] PAIR_STRIDE  = 32'h0000_0008;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
        logic              fault;
    } out_regs_t;

    // byte address of a counter slot: two slots per 4 KiB group
    function automatic logic [31:0] slot_addr(logic [31:0] base, int idx);
        return base + GROUP_STRIDE * 32'(idx / 2) + PAIR_STRIDE * 32'(idx % 2);
    endfunction

    function automatic logic is_mapped(logic [31:0] base, logic [31:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_CNT; i++) begin
            if (a == slot_addr(base, i)) hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/perf_event_decode.sv
module perf_event_decode
    import perf_bank_pkg::*;
(
    input  logic [N_ST-1:0]  state,
    input  logic             mem_req_ready,
    input  logic             rdata_valid,
    input  logic             branch_taken,
    output logic [N_CNT-1:0] events,
    output logic             bad_state
);
    logic mem_req;

    always_comb begin
        mem_req           = state[S_LOAD] | state[S_STORE];
        events            = '0;
        events[E_CYC]     = 1'b1;
        events[E_EXEC]    = state[S_EXEC];
        events[E_ACC]     = mem_req & mem_req_ready;
        events[E_DLY]     = (mem_req & ~mem_req_ready) | (state[S_RWAIT] & ~rdata_valid);
        events[E_TKN]     = state[S_EXEC] & branch_taken;
        events[E_NTK]     = state[S_EXEC] & ~branch_taken;
        bad_state         = ($countones(state) != 1);
    end

endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + W'(inc);
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/perf_read_mux.sv
module perf_read_mux
    import perf_bank_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [31:0] BASE  = 32'h6001_0000
) (
    input  logic [31:0]                  addr,
    input  logic [N_CNT-1:0][CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0]            data
);
    logic [N_CNT-1:0] hit;

    for (genvar g = 0; g < N_CNT; g++) begin : g_hit
        assign hit[g] = (addr == slot_addr(BASE, g));
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < N_CNT; i++) begin
            if (hit[i]) data = data | DATA_W'(cnt[i]);
        end
    end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import perf_bank_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [31:0] BASE  = 32'h6001_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  fsm_state,
    input  logic        mem_req_ready,
    input  logic        rdata_valid,
    input  logic        branch_taken,
    input  logic        rd_en,
    input  logic [31:0] rd_addr,
    output logic [31:0] rd_data,
    output logic        state_fault
);
    logic [N_CNT-1:0]            events;
    logic                        bad_state;
    logic [N_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [DATA_W-1:0]           sel_data;
    out_regs_t                   out_d, out_q;

    perf_event_decode i_decode (
        .state         (fsm_state),
        .mem_req_ready (mem_req_ready),
        .rdata_valid   (rdata_valid),
        .branch_taken  (branch_taken),
        .events        (events),
        .bad_state     (bad_state)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        perf_counter #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (events[g]),
            .count (cnt_val[g])
        );
    end

    perf_read_mux #(.CNT_W(CNT_W), .BASE(BASE)) i_mux (
        .addr (rd_addr),
        .cnt  (cnt_val),
        .data (sel_data)
    );

    always_comb begin
        out_d       = out_q;
        out_d.fault = bad_state;
        if (rd_en) out_d.rd_data = sel_data;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign rd_data     = out_q.rd_data;
    assign state_fault = out_q.fault;

endmodule

// File: rtl/perf_bank_checker.sv
module perf_bank_checker
    import perf_bank_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [31:0] BASE  = 32'h6001_0000
) (
    input logic                        clk,
    input logic                        rst,
    input logic [5:0]                  state,
    input logic                        mem_req_ready,
    input logic                        rdata_valid,
    input logic                        branch_taken,
    input logic                        rd_en,
    input logic [31:0]                 rd_addr,
    input logic [31:0]                 rd_data,
    input logic                        state_fault,
    input logic [N_CNT-1:0][CNT_W-1:0] cnt
);

    a_r1_cycle_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt[E_CYC] == CNT_W'($past(cnt[E_CYC]) + 1'b1));

    a_r2_exec_inc: assert property (@(posedge clk) disable iff (rst)
        state[S_EXEC] |=> cnt[E_EXEC] == CNT_W'($past(cnt[E_EXEC]) + 1'b1));

    a_r2_exec_hold: assert property (@(posedge clk) disable iff (rst)
        !state[S_EXEC] |=> $stable(cnt[E_EXEC]));

    a_r3_access_inc: assert property (@(posedge clk) disable iff (rst)
        ((state[S_LOAD] || state[S_STORE]) && mem_req_ready)
        |=> cnt[E_ACC] == CNT_W'($past(cnt[E_ACC]) + 1'b1));

    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (!((state[S_LOAD] || state[S_STORE]) && !mem_req_ready) && !(state[S_RWAIT] && !rdata_valid))
        |=> $stable(cnt[E_DLY]));

    a_r5_branch_split: assert property (@(posedge clk) disable iff (rst)
        state[S_EXEC] |=> ($stable(cnt[E_TKN]) != $stable(cnt[E_NTK])));

    a_r5_branch_idle: assert property (@(posedge clk) disable iff (rst)
        !state[S_EXEC] |=> ($stable(cnt[E_TKN]) && $stable(cnt[E_NTK])));

    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_mapped(BASE, rd_addr)) |=> rd_data == 32'h0);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt[E_CYC] == {CNT_W{1'b1}}) |=> cnt[E_CYC] == '0);

    a_r11_fault_set: assert property (@(posedge clk) disable iff (rst)
        !$onehot(state) |=> state_fault);

    a_r11_fault_clear: assert property (@(posedge clk) disable iff (rst)
        $onehot(state) |=> !state_fault);

    // branch_taken only matters in execute cycles; keep it observed
    logic unused_ok;
    assign unused_ok = branch_taken;

endmodule

bind perf_counter_bank perf_bank_checker #(.CNT_W(CNT_W), .BASE(BASE)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .state         (fsm_state),
    .mem_req_ready (mem_req_ready),
    .rdata_valid   (rdata_valid),
    .branch_taken  (branch_taken),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .state_fault   (state_fault),
    .cnt           (cnt_val)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;

    localparam logic [31:0] BASE = 32'h6001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  fsm_state = 6'b000001;
    logic        mem_req_ready = 1'b0;
    logic        rdata_valid = 1'b0;
    logic        branch_taken = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_addr = '0;
    logic [31:0] rd_data, rd_data_n;
    logic        state_fault, state_fault_n;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [6];
    logic [31:0] exp_rd = '0;
    logic [31:0] exp_rd_n = '0;
    logic        exp_fault = 1'b0;

    always #5 clk = ~clk;

    perf_counter_bank i_perf_counter_bank (
        .clk(clk), .rst(rst), .fsm_state(fsm_state), .mem_req_ready(mem_req_ready),
        .rdata_valid(rdata_valid), .branch_taken(branch_taken), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .state_fault(state_fault));

    perf_counter_bank #(.CNT_W(8)) i_perf_counter_bank_w8 (
        .clk(clk), .rst(rst), .fsm_state(fsm_state), .mem_req_ready(mem_req_ready),
        .rdata_valid(rdata_valid), .branch_taken(branch_taken), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data_n), .state_fault(state_fault_n));

    // R6: slot k at BASE + (k/2)*0x1000 + (k%2)*8
    function automatic logic [31:0] addr_of(int k);
        return BASE + 32'(k / 2) * 32'h1000 + 32'(k % 2) * 32'h8;
    endfunction

    function automatic int idx_of(logic [31:0] a);
        for (int k = 0; k < 6; k++) if (a == addr_of(k)) return k;
        return -1;
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0: return "R6/R1 cycle";
            1: return "R6/R2 exec";
            2: return "R6/R3 access";
            3: return "R6/R4 stall";
            4: return "R6/R5 taken";
            5: return "R6/R5 not-taken";
            default: return "R7 unmapped";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        string tag;
        logic  ld_st;
        int    k;
        if (rst) begin
            for (int i = 0; i < 6; i++) m[i] = '0;
            exp_rd = '0; exp_rd_n = '0; exp_fault = 1'b0;
            tag = "R9 reset";
        end else begin
            k = idx_of(rd_addr);
            if (rd_en) begin
                exp_rd   = (k < 0) ? 32'h0 : m[k];
                exp_rd_n = (k < 0) ? 32'h0 : {24'h0, m[k][7:0]};
                tag      = tag_of(k);
            end else begin
                tag = "R8 hold";
            end
            exp_fault = ($countones(fsm_state) != 1);
            ld_st = fsm_state[3] | fsm_state[4];
            m[0] = m[0] + 1;
            if (fsm_state[2]) m[1] = m[1] + 1;
            if (ld_st && mem_req_ready) m[2] = m[2] + 1;
            if ((ld_st && !mem_req_ready) || (fsm_state[5] && !rdata_valid)) m[3] = m[3] + 1;
            if (fsm_state[2] && branch_taken) m[4] = m[4] + 1;
            if (fsm_state[2] && !branch_taken) m[5] = m[5] + 1;
        end
        @(posedge clk);
        #1;
        chk(tag, rd_data, exp_rd);
        chk({"R10 narrow ", tag}, rd_data_n, exp_rd_n);
        chk("R11 fault", {31'h0, state_fault}, {31'h0, exp_fault});
        chk("R11 fault narrow", {31'h0, state_fault_n}, {31'h0, exp_fault});
    endtask

    task automatic rand_inputs();
        int r;
        int k;
        r = int'($urandom % 8);
        if (r < 6)       fsm_state = 6'(1 << r);
        else if (r == 6) fsm_state = 6'($urandom);
        else             fsm_state = 6'b000000;
        mem_req_ready = 1'($urandom);
        rdata_valid   = 1'($urandom);
        branch_taken  = 1'($urandom);
        rd_en         = ($urandom % 4) != 0;
        k = int'($urandom % 6);
        r = int'($urandom % 10);
        case (r)
            0:       rd_addr = addr_of(k) + 32'h4;
            1:       rd_addr = addr_of(k) ^ 32'h0000_0100;
            2:       rd_addr = $urandom;
            3:       rd_addr = addr_of(k) + 32'h1;
            default: rd_addr = addr_of(k);
        endcase
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset clears everything
        repeat (3) step();
        rst = 1'b0;
        // directed: read every slot right after reset
        for (int k = 0; k < 6; k++) begin
            rd_en = 1'b1; rd_addr = addr_of(k); fsm_state = 6'b000001;
            step();
        end
        // directed R4: load stalled then read-wait stalled
        rd_en = 1'b0; fsm_state = 6'b001000; mem_req_ready = 1'b0;
        repeat (4) step();
        mem_req_ready = 1'b1; step();
        fsm_state = 6'b100000; rdata_valid = 1'b0;
        repeat (3) step();
        rd_en = 1'b1; rd_addr = addr_of(3); fsm_state = 6'b000010; step();
        rd_en = 1'b1; rd_addr = addr_of(2); step();
        // R11 all-zero state
        fsm_state = 6'b000000; rd_en = 1'b0; step();
        // random traffic, narrow counters wrap several times (R10)
        for (int n = 0; n < 2000; n++) begin
            rand_inputs();
            step();
        end
        // R9 mid-run reset
        rst = 1'b1; rd_en = 1'b1; rd_addr = addr_of(0);
        repeat (2) step();
        rst = 1'b0;
        for (int n = 0; n < 600; n++) begin
            rand_inputs();
            step();
        end
        // R10: read cycle slot after narrow wrap
        rd_en = 1'b1; rd_addr = addr_of(0); fsm_state = 6'b000001;
        step();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule